// File: doc/BRIEF.md
# Pin Change Watch Detector

This block watches a small group of input pins and raises a shared interrupt flag when any of them differs from the value seen at the last port read. Each pin has two capture registers. The first is the current register, loaded when the read strobe rises. The second is the previous register, loaded when the strobe falls. An XOR of the two registers, masked by the pin direction, gives a per-pin mismatch. The OR of all mismatches sets the flag. Software cannot tell which pin caused the flag.

The read strobe is a synchronous level. Both of its edges are found on the system clock. The read data output shows the current register, so software reads the value captured at the start of the read. Software clears the flag with a one-cycle clear input. The mismatch stays present until a later read makes the two registers equal again, so a clear issued while the mismatch is present has no effect.

Top module: `pin_change_watch`

## Requirements
- R1: While reset is active, and after it, the current register, the previous register, the flag and the read data are all 0.
- R2: In the clock edge where the read strobe is 1 and was 0 at the previous edge, the current register loads the pin values. The read data shows this value from the next cycle on.
- R3: In the clock edge where the read strobe is 0 and was 1 at the previous edge, the previous register loads the pin values. The current register does not change at any edge that is not a rising strobe edge.
- R4: A pin's mismatch is the XOR of its current and previous registers. If any pin's mismatch is 1, the flag is 1 after the next edge.
- R5: A pin whose direction bit is 0 (output) never contributes to the mismatch. A pin whose direction bit is 1 (input) does.
- R6: If all masked mismatches are 0, the flag does not rise.
- R7: If a pin changes between the rising and the falling edge of the strobe, the two registers disagree after the falling edge and the flag is set.
- R8: When the clear input and a mismatch occur in the same cycle, setting wins and the flag stays 1.
- R9: The flag stays 1 until a clear arrives in a cycle with no mismatch. In that case it is 0 after the next edge.
- R10: While the strobe is held high, later pin changes do not alter the current register or the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NPINS | Pin levels being watched |
| pin_dir | input | NPINS | Direction per pin, 1 = input, 0 = output |
| rd_strobe | input | 1 | Port read pulse, synchronous level |
| flag_clr | input | 1 | Software clear of the change flag |
| chg_flag | output | 1 | Shared change interrupt flag |
| rd_data | output | NPINS | Contents of the current register |

## Verification
A software clear and a set from a persisting mismatch can fall in the same cycle. The bench provokes this by changing a pin between the two strobe edges, then pulsing the clear while the registers still disagree. The flag is expected to stay 1. It is expected to drop only after a clear that follows a matching read. Random stimulus mixes clears, strobe edges and pin changes, so the two events also coincide in many random cycles. There, the flag is compared each cycle against a model in which setting has priority.

// File: rtl/pcw_pkg.sv
// Package: shared types for the pin change watch detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pcw_pkg;

    // Update applied to the change flag in a given cycle.
    typedef enum logic [1:0] {
        FLG_HOLD = 2'd0,
        FLG_SET  = 2'd1,
        FLG_CLR  = 2'd2
    } flg_act_e;

endpackage

// File: rtl/pcw_strobe_edge.sv
// Module: pcw_strobe_edge
// Finds the rising and falling edges of the synchronous read strobe.
// Assumes: the strobe is already synchronous to clk. Each edge output
// is a single-cycle pulse, seen combinationally in the cycle where the
// strobe differs from its registered copy.
module pcw_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall
);

    logic strobe_q;

    // Register the strobe level so its edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Edge pulses come from comparing the level now with the last one.
    always_comb begin
        rise = strobe & ~strobe_q;
        fall = ~strobe & strobe_q;
    end

    // R3
    falling_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(strobe));

endmodule

// File: rtl/pcw_capture.sv
// Module: pcw_capture
// Holds, per pin, a current register loaded at the rising strobe edge
// and a previous register loaded at the falling edge. Its output is the
// XOR mismatch, masked so that only input pins count.
// Assumes: at most one of rise and fall is high in any cycle.
module pcw_capture #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic [NPINS-1:0] pins,
    input  logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] cur,
    output logic [NPINS-1:0] mis
);

    logic [NPINS-1:0] prev;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic cur_b;
        logic prev_b;

        // Current register: takes the pin level at the start of a read.
        always_ff @(posedge clk) begin
            if (!rst_n)    cur_b <= 1'b0;
            else if (rise) cur_b <= pins[g];
        end

        // Previous register: takes the pin level at the end of a read.
        always_ff @(posedge clk) begin
            if (!rst_n)    prev_b <= 1'b0;
            else if (fall) prev_b <= pins[g];
        end

        // Mismatch counts only when the pin is set up as an input.
        always_comb begin
            cur[g]  = cur_b;
            prev[g] = prev_b;
            mis[g]  = (cur_b ^ prev_b) & dir[g];
        end
    end

    // R2
    cur_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> cur == $past(pins));

    // R3
    prev_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> prev == $past(pins));

    // R10
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(cur));

endmodule

// File: rtl/pcw_flag.sv
// Module: pcw_flag
// Sticky change flag. A mismatch sets it and a software clear resets
// it. When both happen in the same cycle, setting wins.
// Assumes: any_mis is the OR of the masked per-pin mismatches.
module pcw_flag
    import pcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_mis,
    input  logic clr,
    output logic flag
);

    flg_act_e act;

    // Choose this cycle's update; a set outranks a clear.
    always_comb begin
        if (any_mis)  act = FLG_SET;
        else if (clr) act = FLG_CLR;
        else          act = FLG_HOLD;
    end

    // Apply the chosen update to the flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            case (act)
                FLG_SET: flag <= 1'b1;
                FLG_CLR: flag <= 1'b0;
                default: flag <= flag;
            endcase
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_mis |=> flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R6
    no_false_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !any_mis) |=> !flag);

endmodule

// File: rtl/pin_change_watch.sv
// Module: pin_change_watch (top)
// Detects a change on any watched input pin since the last port read,
// using two-phase capture around the read strobe. Sets a shared flag.
// Assumes: pins and strobe are synchronous to clk; reset is synchronous
// and active low.
module pin_change_watch #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_dir,
    input  logic             rd_strobe,
    input  logic             flag_clr,
    output logic             chg_flag,
    output logic [NPINS-1:0] rd_data
);

    logic             rise;
    logic             fall;
    logic [NPINS-1:0] cur;
    logic [NPINS-1:0] mis;
    logic             any_mis;

    pcw_strobe_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rise),
        .fall   (fall)
    );

    pcw_capture #(.NPINS(NPINS)) i_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .fall  (fall),
        .pins  (pin_in),
        .dir   (pin_dir),
        .cur   (cur),
        .mis   (mis)
    );

    // Fold the per-pin mismatches into one change request.
    always_comb begin
        any_mis = |mis;
        rd_data = cur;
    end

    pcw_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_mis (any_mis),
        .clr     (flag_clr),
        .flag    (chg_flag)
    );

    // R5
    output_pins_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mis & ~pin_dir) == '0));

    // R4
    flag_follows_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mis != '0) |=> chg_flag);

endmodule

// File: tb/test_pin_change_watch.sv
`timescale 1ns/1ps
module test_pin_change_watch;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_dir = '1;
    logic         rd_strobe = 1'b0;
    logic         flag_clr = 1'b0;
    logic         chg_flag;
    logic [N-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements.
    logic [N-1:0] m_cur = '0, m_prev = '0;
    logic         m_sq = 1'b0, m_flag = 1'b0;

    always #2.5 clk = ~clk;

    pin_change_watch #(.NPINS(N)) i_pin_change_watch (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .rd_strobe(rd_strobe), .flag_clr(flag_clr),
        .chg_flag(chg_flag), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic next_flag(input logic [N-1:0] c, input logic [N-1:0] p,
                                       input logic [N-1:0] d, input logic f, input logic clr);
        if (|((c ^ p) & d)) return 1'b1;
        if (clr) return 1'b0;
        return f;
    endfunction

    // One clock: update the model at the edge, compare at the negedge.
    task automatic step();
        logic rise, fall;
        @(posedge clk);
        if (!rst_n) begin
            m_cur = '0; m_prev = '0; m_sq = 1'b0; m_flag = 1'b0;
        end else begin
            rise = rd_strobe & ~m_sq;
            fall = ~rd_strobe & m_sq;
            m_flag = next_flag(m_cur, m_prev, pin_dir, m_flag, flag_clr);
            if (rise) m_cur = pin_in;
            if (fall) m_prev = pin_in;
            m_sq = rd_strobe;
        end
        @(negedge clk);
        chk("R4 flag model", {{(N-1){1'b0}}, chg_flag}, {{(N-1){1'b0}}, m_flag});
        chk("R2 rd_data model", rd_data, m_cur);
    endtask

    task automatic read_pulse(input logic [N-1:0] first, input logic [N-1:0] mid);
        rd_strobe = 1'b1; pin_in = first; step();
        pin_in = mid; step();
        rd_strobe = 1'b0; step();
        step();
    endtask

    task automatic clear_pulse();
        flag_clr = 1'b1; step();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        @(negedge clk);
        rd_strobe = 1'b1; pin_in = 4'hF;
        repeat (3) step();
        // R1: registers are zero under reset even with strobe and pins high
        chk("R1 flag", {{(N-1){1'b0}}, chg_flag}, '0);
        chk("R1 rd_data", rd_data, '0);
        rd_strobe = 1'b0; pin_in = '0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 flag after reset", {{(N-1){1'b0}}, chg_flag}, '0);

        // R2 first read of 4'hA: disagrees with reset previous value, then settles
        pin_dir = 4'hF;
        read_pulse(4'hA, 4'hA);
        chk("R2 rd_data", rd_data, 4'hA);
        chk("R4 flag set", {{(N-1){1'b0}}, chg_flag}, 4'h1);
        clear_pulse();
        chk("R9 clear without mismatch", {{(N-1){1'b0}}, chg_flag}, '0);

        // R6 repeat read of unchanged pins
        read_pulse(4'hA, 4'hA);
        chk("R6 no change no flag", {{(N-1){1'b0}}, chg_flag}, '0);

        // R7 change between the strobe edges
        read_pulse(4'hA, 4'h5);
        chk("R7 mid-read change", {{(N-1){1'b0}}, chg_flag}, 4'h1);
        chk("R7 rd_data kept", rd_data, 4'hA);
        // R8 clear while the mismatch persists
        clear_pulse();
        chk("R8 set wins", {{(N-1){1'b0}}, chg_flag}, 4'h1);
        read_pulse(4'h5, 4'h5);
        chk("R9 sticky after match", {{(N-1){1'b0}}, chg_flag}, 4'h1);
        clear_pulse();
        chk("R9 cleared", {{(N-1){1'b0}}, chg_flag}, '0);

        // R5 changes only on output-configured pins
        pin_dir = 4'b0011;
        read_pulse(4'h5, 4'h9);
        chk("R5 output pins ignored", {{(N-1){1'b0}}, chg_flag}, '0);
        chk("R5 rd_data", rd_data, 4'h5);
        pin_dir = 4'hF;
        step(); step();
        chk("R5 input pin counts", {{(N-1){1'b0}}, chg_flag}, 4'h1);
        read_pulse(4'h9, 4'h9);
        clear_pulse();

        // R10 strobe held high while pins move
        rd_strobe = 1'b1; pin_in = 4'h3; step();
        for (int k = 0; k < 5; k++) begin
            pin_in = 4'(k * 5 + 6);
            step();
            chk("R10 hold", rd_data, 4'h3);
        end
        rd_strobe = 1'b0; step(); step();
        clear_pulse();

        // R3 R4 R8 random mix of reads, clears and direction changes
        for (int i = 0; i < 3000; i++) begin
            pin_in = 4'($urandom);
            pin_dir = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            if ($urandom % 3 == 0) rd_strobe = ~rd_strobe;
            flag_clr = ($urandom % 6 == 0);
            step();
        end
        flag_clr = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule